// File: doc/BRIEF.md
# Pixel Attribute Stage with Toggling Host Port

This block is the last colour stage of a 16-colour planar display pipe. It takes a 4-bit pixel per transfer together with a blanking flag and produces the 8-bit colour index that goes on to the colour lookup DAC. Along the way it masks the pixel with a plane mask and looks the result up in a 16-entry palette of 6-bit values. Two colour-select bits are placed above the palette value. During blanking it sends a border colour instead, and when video is switched off it sends zero. It also drives a 3-bit fine horizontal shift, which the downstream pixel shifter uses to move the picture by single pixels.

The host programs the stage through a small register port. One write port serves both the index and the data. An internal toggle decides which role each write takes. Reading the status port returns the toggle to its index state, so software can always resynchronise before programming. The index byte holds a 5-bit register number and a video-enable bit. Pixel input and colour output are valid/ready streams. An output held by a low `col_ready` keeps its value, and the input is then not accepted.

Top module: `attr_ctrl`

## Requirements
- R1: After reset the toggle is in its index state, the index byte is zero (register 0, video off), every register is zero, `col_valid` is low and `pan_shift` is zero.
- R2: Each write on port 0 flips the toggle. In the index state the write loads the index byte: bits 4:0 are the register number and bit 5 is video enable. In the data state the write goes to the selected register and leaves the index byte unchanged.
- R3: A read on port 2 returns the toggle in bit 0 (1 means the next port-0 write is data, upper bits zero). After that read the toggle is in its index state, so the next port-0 write is taken as an index.
- R4: A read on port 1 returns the selected register, zero-extended. Registers 0–15 are the 6-bit palette entries. Register 16 is an 8-bit mode value, register 17 is the 8-bit border colour, register 18 is the 4-bit plane mask, register 19 is the 3-bit shift and register 20 is the 2-bit colour select. Data writes to numbers 21–31 are discarded and read back as zero.
- R5: A read on port 0 returns the index byte {00, video enable, register number}. Writes on ports 1, 2 and 3 change neither the registers, the index byte nor the toggle.
- R6: With video enabled and blank low, an accepted pixel p yields `col_index` = {colour select, palette[p & plane mask]}.
- R7: With video enabled and blank high, an accepted pixel yields `col_index` equal to the border colour register.
- R8: With video disabled, every accepted pixel yields `col_index` = 0, whether blank is high or low.
- R9: `pan_shift` equals the low 3 bits of the last value written to register 19.
- R10: A pixel accepted at a clock edge appears on `col_valid`/`col_index` after that edge. `pix_ready` is high whenever the output is empty or `col_ready` is high. While `col_valid` is high and `col_ready` is low, `col_valid` and `col_index` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_port | input | 2 | Port select: 0 index/data, 1 register read, 2 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_rd is high (zero otherwise) |
| pan_shift | output | 3 | Fine horizontal shift |
| pix_valid | input | 1 | Pixel input valid |
| pix_ready | output | 1 | Pixel input ready |
| pix_in | input | 4 | Pixel value from the planes |
| pix_blank | input | 1 | Pixel lies in the blanking region |
| col_valid | output | 1 | Colour output valid |
| col_ready | input | 1 | Colour output ready |
| col_index | output | 8 | Colour index to the DAC |

## Verification
The palette path is swept over all 16 pixel values under four plane masks and two colour-select values. The full mask catches a wrong palette address. The alternating masks catch a mask applied on the wrong bits, and the zero mask shows that every pixel collapses onto entry 0. A readback sweep over all 32 register numbers runs after discarded writes to the unused numbers, which separates a good address decode from aliasing. Host sequences interleave index writes, data writes, status reads and writes to the wrong ports. These tell a correct toggle apart from one that ignores the status read or toggles on foreign ports. A stalled output shows whether the held value survives back-pressure.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int IDX_W   = 5;
  localparam int VEN_BIT = 5;

  typedef enum logic [1:0] {
    PORT_IDXDATA = 2'd0,
    PORT_RDDATA  = 2'd1,
    PORT_STATUS  = 2'd2,
    PORT_SPARE   = 2'd3
  } port_e;
endpackage

// File: rtl/attr_host_port.sv
module attr_host_port
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       port,
  input  logic [VEN_BIT:0] idx_byte,
  output logic [IDX_W-1:0] sel_idx,
  output logic             video_en,
  output logic             expect_data,
  output logic             data_we
);
  logic wr_main, rd_status;

  assign wr_main   = wr && (port == PORT_IDXDATA);
  assign rd_status = rd && (port == PORT_STATUS);
  assign data_we   = wr_main && expect_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expect_data <= 1'b0;
      sel_idx     <= '0;
      video_en    <= 1'b0;
    end else begin
      if (wr_main) begin
        if (!expect_data) begin
          sel_idx     <= idx_byte[IDX_W-1:0];
          video_en    <= idx_byte[VEN_BIT];
          expect_data <= 1'b1;
        end else begin
          expect_data <= 1'b0;
        end
      end
      if (rd_status) expect_data <= 1'b0;
    end
  end

  // R2: every port-0 write flips the toggle
  assert_ff_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_main && !rd_status) |=> (expect_data != $past(expect_data)));

  // R3: status read returns the toggle to index state
  assert_ff_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> !expect_data);

  // R2: a data write leaves the index byte alone
  assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> ($stable(sel_idx) && $stable(video_en)));
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_pkg::*;
#(
  parameter int PIX_W  = 4,
  parameter int PAL_W  = 6,
  parameter int DATA_W = 8,
  parameter int PAN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PIX_W-1:0]  lookup_addr,
  output logic [PAL_W-1:0]  lookup_data,
  output logic [DATA_W-1:0] ovsc,
  output logic [PIX_W-1:0]  plane_mask,
  output logic [PAN_W-1:0]  pan,
  output logic [DATA_W-PAL_W-1:0] csel,
  output logic [DATA_W-1:0] rd_val
);
  localparam int NUM_PAL = 1 << PIX_W;
  localparam int CSEL_W  = DATA_W - PAL_W;
  localparam logic [IDX_W-1:0] A_MODE  = IDX_W'(NUM_PAL);
  localparam logic [IDX_W-1:0] A_OVSC  = IDX_W'(NUM_PAL + 1);
  localparam logic [IDX_W-1:0] A_PLANE = IDX_W'(NUM_PAL + 2);
  localparam logic [IDX_W-1:0] A_PAN   = IDX_W'(NUM_PAL + 3);
  localparam logic [IDX_W-1:0] A_CSEL  = IDX_W'(NUM_PAL + 4);
  localparam int NUM_REGS = NUM_PAL + 5;

  logic [PAL_W-1:0]  pal_q [NUM_PAL];
  logic [DATA_W-1:0] mode_q;

  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
    always_ff @(posedge clk) begin
      if (!rst_n)                                pal_q[g] <= '0;
      else if (we && idx == IDX_W'(g))           pal_q[g] <= wdata[PAL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      ovsc       <= '0;
      plane_mask <= '0;
      pan        <= '0;
      csel       <= '0;
    end else if (we) begin
      case (idx)
        A_MODE:  mode_q     <= wdata;
        A_OVSC:  ovsc       <= wdata;
        A_PLANE: plane_mask <= wdata[PIX_W-1:0];
        A_PAN:   pan        <= wdata[PAN_W-1:0];
        A_CSEL:  csel       <= wdata[CSEL_W-1:0];
        default: ;
      endcase
    end
  end

  assign lookup_data = pal_q[lookup_addr];

  always_comb begin
    rd_val = '0;
    if (idx < IDX_W'(NUM_PAL)) begin
      rd_val = DATA_W'(pal_q[idx[PIX_W-1:0]]);
    end else begin
      case (idx)
        A_MODE:  rd_val = mode_q;
        A_OVSC:  rd_val = ovsc;
        A_PLANE: rd_val = DATA_W'(plane_mask);
        A_PAN:   rd_val = DATA_W'(pan);
        A_CSEL:  rd_val = DATA_W'(csel);
        default: rd_val = '0;
      endcase
    end
  end

  // R4: writes above the last register touch nothing
  assert_unused_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx >= IDX_W'(NUM_REGS)) |=>
      ($stable(mode_q) && $stable(ovsc) && $stable(plane_mask) && $stable(pan) && $stable(csel)));

  // R9: shift register follows a write to its slot
  assert_pan_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == A_PAN) |=> (pan == $past(wdata[PAN_W-1:0])));
endmodule

// File: rtl/attr_pixel_pipe.sv
module attr_pixel_pipe #(
  parameter int PIX_W  = 4,
  parameter int PAL_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              pix_blank,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [DATA_W-1:0] col_index,
  input  logic              video_en,
  input  logic [PIX_W-1:0]  plane_mask,
  input  logic [DATA_W-1:0] ovsc,
  input  logic [DATA_W-PAL_W-1:0] csel,
  output logic [PIX_W-1:0]  lookup_addr,
  input  logic [PAL_W-1:0]  lookup_data
);
  logic              take;
  logic [DATA_W-1:0] next_index;

  assign pix_ready   = !col_valid || col_ready;
  assign take        = pix_valid && pix_ready;
  assign lookup_addr = pix_in & plane_mask;

  always_comb begin
    if (!video_en)      next_index = '0;
    else if (pix_blank) next_index = ovsc;
    else                next_index = {csel, lookup_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_index <= '0;
    end else if (take) begin
      col_valid <= 1'b1;
      col_index <= next_index;
    end else if (col_ready) begin
      col_valid <= 1'b0;
    end
  end

  // R10: a stalled output holds
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |=> (col_valid && $stable(col_index)));

  // R10: an accepted pixel shows up on the next cycle
  assert_accept_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> col_valid);

  // R8: video off gives zero
  assert_video_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !video_en) |=> (col_index == '0));

  // R7: blanking gives the border colour
  assert_border_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && video_en && pix_blank) |=> (col_index == $past(ovsc)));
endmodule

// File: rtl/attr_ctrl.sv
module attr_ctrl
  import attr_pkg::*;
#(
  parameter int PIX_W  = 4,
  parameter int PAL_W  = 6,
  parameter int DATA_W = 8,
  parameter int PAN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_port,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [PAN_W-1:0]  pan_shift,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              pix_blank,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [DATA_W-1:0] col_index
);
  localparam int CSEL_W = DATA_W - PAL_W;

  logic [IDX_W-1:0]  sel_idx;
  logic              video_en, expect_data, data_we;
  logic [PIX_W-1:0]  lookup_addr, plane_mask;
  logic [PAL_W-1:0]  lookup_data;
  logic [DATA_W-1:0] ovsc, rd_val;
  logic [CSEL_W-1:0] csel;

  attr_host_port u_host (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .rd(host_rd), .port(host_port),
    .idx_byte(host_wdata[VEN_BIT:0]), .sel_idx(sel_idx), .video_en(video_en),
    .expect_data(expect_data), .data_we(data_we)
  );

  attr_regfile #(.PIX_W(PIX_W), .PAL_W(PAL_W), .DATA_W(DATA_W), .PAN_W(PAN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(data_we), .idx(sel_idx), .wdata(host_wdata),
    .lookup_addr(lookup_addr), .lookup_data(lookup_data), .ovsc(ovsc),
    .plane_mask(plane_mask), .pan(pan_shift), .csel(csel), .rd_val(rd_val)
  );

  attr_pixel_pipe #(.PIX_W(PIX_W), .PAL_W(PAL_W), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_in(pix_in), .pix_blank(pix_blank), .col_valid(col_valid),
    .col_ready(col_ready), .col_index(col_index), .video_en(video_en),
    .plane_mask(plane_mask), .ovsc(ovsc), .csel(csel),
    .lookup_addr(lookup_addr), .lookup_data(lookup_data)
  );

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_port)
        PORT_IDXDATA: host_rdata = DATA_W'({video_en, sel_idx});
        PORT_RDDATA:  host_rdata = rd_val;
        PORT_STATUS:  host_rdata = DATA_W'(expect_data);
        default:      host_rdata = '0;
      endcase
    end
  end

  // R5: writes on foreign ports leave the toggle alone
  assert_foreign_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_port != PORT_IDXDATA && !host_rd) |=> $stable(expect_data));
endmodule

// File: tb/tb_attr_ctrl.sv
module tb_attr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_port = 2'd3;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [2:0] pan_shift;
  logic       pix_valid = 1'b0, pix_ready, pix_blank = 1'b0;
  logic [3:0] pix_in = 4'h0;
  logic       col_valid, col_ready = 1'b1;
  logic [7:0] col_index;

  int total = 0;
  int bad = 0;

  logic [5:0] pal_m [16];
  logic [7:0] ovsc_m = 8'h9C;
  logic [7:0] mode_m = 8'hA5;
  logic [3:0] plane_m;
  logic [1:0] csel_m;
  logic [2:0] pan_m;

  attr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pan_shift(pan_shift), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_in(pix_in), .pix_blank(pix_blank), .col_valid(col_valid),
    .col_ready(col_ready), .col_index(col_index)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_port = p; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_port = 2'd3;
  endtask

  task automatic hread(input logic [1:0] p, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_port = p;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; host_port = 2'd3;
  endtask

  task automatic set_reg(input logic [4:0] idx, input logic [7:0] val, input logic ven);
    logic [7:0] dummy;
    hread(2'd2, dummy);
    hwrite(2'd0, {2'b00, ven, idx});
    hwrite(2'd0, val);
  endtask

  task automatic send_pix(input logic [3:0] p, input logic blank, output logic [7:0] c, output logic v);
    @(negedge clk);
    pix_valid = 1'b1; pix_in = p; pix_blank = blank; col_ready = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    c = col_index; v = col_valid;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, c;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 col_valid", col_valid, 1'b0);
    chk("R1 pan_shift", pan_shift, 3'd0);
    hread(2'd0, r); chk("R1 index byte", r, 8'h00);
    hread(2'd1, r); chk("R1 palette0", r, 8'h00);
    hread(2'd2, r); chk("R1 toggle", r, 8'h00);

    // R2 alternation
    hwrite(2'd0, 8'h25);
    hread(2'd0, r); chk("R2 index loaded", r, 8'h25);
    hread(2'd2, r); chk("R2 toggle after index", r, 8'h01);
    hwrite(2'd0, 8'h25);
    hwrite(2'd0, 8'h2A);
    hread(2'd2, r); chk("R2 toggle after data", r, 8'h00);
    hread(2'd0, r); chk("R2 index kept by data write", r, 8'h25);
    hread(2'd1, r); chk("R2 data landed", r, 8'h2A);

    // R3 status read resynchronises
    hwrite(2'd0, 8'h23);
    hread(2'd2, r); chk("R3 status shows data state", r, 8'h01);
    hwrite(2'd0, 8'h33);
    hread(2'd0, r); chk("R3 write after status is index", r, 8'h33);

    // R5 foreign-port writes ignored
    hread(2'd2, r);
    hwrite(2'd0, 8'h25);
    hwrite(2'd1, 8'h11);
    hwrite(2'd2, 8'h12);
    hwrite(2'd3, 8'h13);
    hread(2'd0, r); chk("R5 index unchanged", r, 8'h25);
    hread(1'b1, r); chk("R5 register unchanged", r, 8'h2A);
    hread(2'd2, r); chk("R5 toggle unchanged", r, 8'h01);

    // program registers
    for (int i = 0; i < 16; i++) begin
      pal_m[i] = 6'((i * 11 + 7) & 63);
      set_reg(5'(i), {2'b11, pal_m[i]}, 1'b1);
    end
    set_reg(5'd16, mode_m, 1'b1);
    set_reg(5'd17, ovsc_m, 1'b1);
    plane_m = 4'hF; set_reg(5'd18, 8'hFF, 1'b1);
    pan_m = 3'd5;   set_reg(5'd19, 8'h05, 1'b1);
    csel_m = 2'd2;  set_reg(5'd20, 8'hFE, 1'b1);
    for (int i = 21; i < 32; i++) set_reg(5'(i), 8'hFF, 1'b1);

    // R4 readback sweep
    for (int i = 0; i < 32; i++) begin
      logic [7:0] e;
      if (i < 16) e = {2'b00, pal_m[i]};
      else if (i == 16) e = mode_m;
      else if (i == 17) e = ovsc_m;
      else if (i == 18) e = {4'h0, plane_m};
      else if (i == 19) e = {5'h00, pan_m};
      else if (i == 20) e = {6'h00, csel_m};
      else e = 8'h00;
      hread(2'd2, r);
      hwrite(2'd0, 8'(32 + i));
      hread(2'd1, r);
      chk($sformatf("R4 readback reg %0d", i), r, e);
    end

    // R9 fine shift
    chk("R9 shift value", pan_shift, 3'd5);
    set_reg(5'd19, 8'h0E, 1'b1);
    chk("R9 shift low bits", pan_shift, 3'd6);

    // R6 palette path sweep
    for (int m = 0; m < 4; m++) begin
      logic [3:0] mask;
      mask = (m == 0) ? 4'hF : (m == 1) ? 4'h5 : (m == 2) ? 4'hA : 4'h0;
      set_reg(5'd18, {4'h0, mask}, 1'b1);
      for (int s = 0; s < 2; s++) begin
        logic [1:0] cs;
        cs = (s == 0) ? 2'd1 : 2'd3;
        set_reg(5'd20, {6'h00, cs}, 1'b1);
        for (int p = 0; p < 16; p++) begin
          send_pix(4'(p), 1'b0, c, v);
          chk($sformatf("R6 pix %0d mask %0h", p, mask), c, {cs, pal_m[4'(p) & mask]});
          chk("R10 valid after accept", v, 1'b1);
        end
      end
    end

    // R7 border during blanking
    for (int p = 0; p < 16; p += 5) begin
      send_pix(4'(p), 1'b1, c, v);
      chk("R7 border colour", c, ovsc_m);
    end

    // R10 drain and back-pressure
    @(negedge clk);
    chk("R10 empty after drain", col_valid, 1'b0);
    set_reg(5'd18, 8'h0F, 1'b1);
    @(negedge clk);
    col_ready = 1'b0; pix_valid = 1'b1; pix_in = 4'd3; pix_blank = 1'b0;
    @(negedge clk);
    pix_in = 4'd9;
    chk("R10 first held", col_index, {2'd3, pal_m[3]});
    chk("R10 ready low when stalled", pix_ready, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 still held", col_index, {2'd3, pal_m[3]});
    chk("R10 valid held", col_valid, 1'b1);
    col_ready = 1'b1;
    #1 chk("R10 ready follows col_ready", pix_ready, 1'b1);
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R10 second after release", col_index, {2'd3, pal_m[9]});

    // R8 video off
    hread(2'd2, r);
    hwrite(2'd0, 8'h05);
    send_pix(4'd7, 1'b0, c, v);
    chk("R8 video off pixel", c, 8'h00);
    send_pix(4'd7, 1'b1, c, v);
    chk("R8 video off blank", c, 8'h00);
    hread(2'd1, r);
    chk("R8 palette kept while off", r, {2'b00, pal_m[5]});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule